// File: doc/BRIEF.md
# Single-Precision to Signed 32-bit Integer Converter

This block converts one IEEE single-precision operand into a two's-complement 32-bit integer. It takes one request per cycle. The result, a write-enable and two status flags appear one clock edge after the request is sampled. The rounding direction comes from a 2-bit mode input. A separate truncate select overrides that mode and forces rounding toward zero.

An operand is invalid when it is a NaN, when it is an infinity, or when its rounded value does not fit in a signed 32-bit integer. The range test is made after rounding, so -2^31 is accepted as a valid result. The invalid mask input chooses what happens on an invalid operand:

- **Mask high:** the block writes the integer-indefinite code 0x80000000.
- **Mask low:** the block writes nothing and the held result keeps its old value.

The invalid flag is raised in both cases. The precision flag reports a valid conversion that dropped nonzero fraction bits.

Inside the block, the 24-bit significand is aligned by a barrel shift. It is then rounded using a guard bit and a sticky bit, and negated when the operand sign is set.

Top module: `fcvt_int32`

## Requirements
- R1: After reset, result is 0 and wrEn, invFlag and precFlag are all low.
- R2: A request sampled with start high is reflected on the outputs after exactly that clock edge. After an edge where start was low, wrEn, invFlag and precFlag are low.
- R3: When truncSel is low, rndMode selects the rounding direction: 0 is nearest with ties to even, 1 is toward minus infinity, 2 is toward plus infinity, 3 is toward zero.
- R4: When truncSel is high, the operand is rounded toward zero whatever rndMode holds.
- R5: An operand whose exponent field (bits 30:23) is all ones, that is any NaN or infinity, is invalid.
- R6: A finite operand is invalid when its rounded value is above 2^31-1 or below -2^31. A rounded value of exactly -2^31 is valid and gives 0x80000000 with invFlag low.
- R7: On an invalid operand with invMask high, the block writes 0x80000000, drives wrEn high and raises invFlag. A valid operand converts normally whatever the value of invMask.
- R8: On an invalid operand with invMask low, wrEn stays low, invFlag is raised, and result keeps the value it held before the request.
- R9: precFlag is raised only for a valid conversion that discarded nonzero fraction bits. It is low for exact conversions and for every invalid operand.
- R10: Magnitudes below 1 give -1, 0 or +1 depending on the rounding direction. Denormal operands behave as tiny nonzero values. Both -0.0 and +0.0 give 0 with precFlag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe; the operand is converted on this edge |
| operand | input | 32 | Single-precision source value |
| rndMode | input | 2 | Rounding direction (see R3) |
| truncSel | input | 1 | Forces round toward zero |
| invMask | input | 1 | High: write the indefinite code on invalid; low: suppress the write |
| result | output | 32 | Held integer result |
| wrEn | output | 1 | High for one cycle when result was written |
| invFlag | output | 1 | Invalid-operation flag for the last request |
| precFlag | output | 1 | Inexact flag for the last request |

## Verification
The bench builds the block with its default widths: an 8-bit exponent, a 23-bit fraction field and a 32-bit integer. These defaults make the true limits reachable:

- the exact -2^31 boundary;
- the largest representable values on either side of it (0x4EFFFFFF and 0xCEFFFFFF);
- the first single-precision value beyond -2^31.

With the same defaults, every rounding direction can be exercised on ties, on non-ties, on sub-unity values and on denormals. Because there is no wider integer path, overflow can only be reached through the range check. That check is therefore exercised both by huge finite operands and by specials.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_DOWN = 2'd1,
    RND_UP   = 2'd2,
    RND_ZERO = 2'd3
  } rnd_mode_e;

  typedef struct packed {
    logic writeConv;
    logic writeIndef;
    logic raiseInv;
    logic raisePrec;
  } strobe_t;

endpackage

// File: rtl/fcvt_ctrl.sv
module fcvt_ctrl
  import fcvt_pkg::*;
#(
  parameter int EXP_W = 8
) (
  input  logic             start,
  input  logic [EXP_W-1:0] expField,
  input  logic             invMask,
  input  logic             outOfRange,
  input  logic             inexact,
  output strobe_t          strb
);

  logic isSpecial;
  logic invalid;

  always_comb begin
    isSpecial       = &expField;
    invalid         = isSpecial | outOfRange;
    strb.writeConv  = start & ~invalid;
    strb.writeIndef = start & invalid & invMask;
    strb.raiseInv   = start & invalid;
    strb.raisePrec  = start & ~invalid & inexact;
  end

endmodule

// File: rtl/fcvt_dp.sv
module fcvt_dp
  import fcvt_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [EXP_W+MAN_W:0]   operand,
  input  logic [1:0]             rndMode,
  input  logic                   truncSel,
  input  strobe_t                strb,
  output logic                   outOfRange,
  output logic                   inexact,
  output logic [INT_W-1:0]       result,
  output logic                   wrEn,
  output logic                   invFlag,
  output logic                   precFlag
);

  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int SIG_W  = MAN_W + 1;
  localparam int WIDE_W = SIG_W + INT_W + 1;
  localparam int INTP_W = WIDE_W - MAN_W;
  localparam int SH_W   = $clog2(INT_W + 1);
  localparam int ES_W   = EXP_W + 2;
  localparam logic [INTP_W-1:0] POS_LIM = INTP_W'((64'd1 << (INT_W - 1)) - 1);
  localparam logic [INTP_W-1:0] NEG_LIM = INTP_W'(64'd1 << (INT_W - 1));
  localparam logic [INT_W-1:0]  INDEF   = {1'b1, {(INT_W-1){1'b0}}};

  logic              sign;
  logic [EXP_W-1:0]  expF;
  logic [MAN_W-1:0]  man;
  logic signed [ES_W-1:0] expS;
  logic [SIG_W-1:0]  sig;
  logic [WIDE_W-1:0] wide;
  logic [SH_W-1:0]   shAmt;
  logic [INTP_W-1:0] intPart;
  logic [INTP_W-1:0] rounded;
  logic              guardBit;
  logic              stickyBit;
  logic              bigVal;
  logic              roundUp;
  logic [INT_W-1:0]  convVal;
  rnd_mode_e         effMode;

  assign sign  = operand[EXP_W+MAN_W];
  assign expF  = operand[EXP_W+MAN_W-1:MAN_W];
  assign man   = operand[MAN_W-1:0];
  assign expS  = $signed({2'b00, expF}) - ES_W'(BIAS);
  assign sig   = {|expF, man};
  assign shAmt = expS[SH_W-1:0];

  // Alignment: binary point of the shifted value sits at bit MAN_W
  always_comb begin
    wide      = '0;
    intPart   = '0;
    guardBit  = 1'b0;
    stickyBit = 1'b0;
    bigVal    = 1'b0;
    if (expF == '0) begin
      stickyBit = |man;
    end else if (expS > ES_W'(INT_W)) begin
      bigVal = 1'b1;
    end else if (expS >= 0) begin
      wide      = WIDE_W'(sig) << shAmt;
      intPart   = wide[WIDE_W-1:MAN_W];
      guardBit  = wide[MAN_W-1];
      stickyBit = |wide[MAN_W-2:0];
    end else if (expS == -1) begin
      guardBit  = 1'b1;
      stickyBit = |man;
    end else begin
      stickyBit = 1'b1;
    end
  end

  // Rounding increment on the magnitude
  always_comb begin
    effMode = truncSel ? RND_ZERO : rnd_mode_e'(rndMode);
    unique case (effMode)
      RND_NEAR: roundUp = guardBit & (stickyBit | intPart[0]);
      RND_DOWN: roundUp = sign & (guardBit | stickyBit);
      RND_UP:   roundUp = ~sign & (guardBit | stickyBit);
      default:  roundUp = 1'b0;
    endcase
  end

  assign rounded    = intPart + INTP_W'(roundUp);
  assign outOfRange = bigVal | (sign ? (rounded > NEG_LIM) : (rounded > POS_LIM));
  assign inexact    = guardBit | stickyBit;
  assign convVal    = sign ? (~rounded[INT_W-1:0] + 1'b1) : rounded[INT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      wrEn     <= 1'b0;
      invFlag  <= 1'b0;
      precFlag <= 1'b0;
    end else begin
      if (strb.writeIndef)     result <= INDEF;
      else if (strb.writeConv) result <= convVal;
      wrEn     <= strb.writeConv | strb.writeIndef;
      invFlag  <= strb.raiseInv;
      precFlag <= strb.raisePrec;
    end
  end

endmodule

// File: rtl/fcvt_int32.sv
module fcvt_int32
  import fcvt_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [EXP_W+MAN_W:0] operand,
  input  logic [1:0]           rndMode,
  input  logic                 truncSel,
  input  logic                 invMask,
  output logic [INT_W-1:0]     result,
  output logic                 wrEn,
  output logic                 invFlag,
  output logic                 precFlag
);

  strobe_t strb;
  logic    outOfRange;
  logic    inexact;

  fcvt_ctrl #(.EXP_W(EXP_W)) u_ctrl (
    .start      (start),
    .expField   (operand[EXP_W+MAN_W-1:MAN_W]),
    .invMask    (invMask),
    .outOfRange (outOfRange),
    .inexact    (inexact),
    .strb       (strb)
  );

  fcvt_dp #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .operand    (operand),
    .rndMode    (rndMode),
    .truncSel   (truncSel),
    .strb       (strb),
    .outOfRange (outOfRange),
    .inexact    (inexact),
    .result     (result),
    .wrEn       (wrEn),
    .invFlag    (invFlag),
    .precFlag   (precFlag)
  );

endmodule

// File: rtl/fcvt_int32_chk.sv
module fcvt_int32_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic [EXP_W+MAN_W:0] operand,
  input logic                 invMask,
  input logic [INT_W-1:0]     result,
  input logic                 wrEn,
  input logic                 invFlag,
  input logic                 precFlag
);

  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [EXP_W+MAN_W:0] MIN_OP =
    {1'b1, EXP_W'((1 << (EXP_W - 1)) - 1 + INT_W - 1), {MAN_W{1'b0}}};

  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!wrEn && !invFlag && !precFlag));

  a_r5_special: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (&operand[EXP_W+MAN_W-1:MAN_W])) |=> (invFlag && !precFlag));

  a_r6_min_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (start && operand == MIN_OP) |=> (wrEn && !invFlag && result == INDEF));

  a_r7_indef_code: assert property (@(posedge clk) disable iff (!rst_n)
    (invFlag && wrEn) |-> (result == INDEF));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !invMask) ##1 invFlag |-> (!wrEn && $stable(result)));

  a_r9_prec_excl: assert property (@(posedge clk) disable iff (!rst_n)
    precFlag |-> (wrEn && !invFlag));

endmodule

bind fcvt_int32 fcvt_int32_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .operand  (operand),
  .invMask  (invMask),
  .result   (result),
  .wrEn     (wrEn),
  .invFlag  (invFlag),
  .precFlag (precFlag)
);

// File: tb/sim_fcvt_int32.sv
module sim_fcvt_int32;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 46;

  // Row: operand, mode, trunc, mask, expected result, wrEn, invFlag, precFlag
  localparam logic [70:0] TBL [NV] = '{
    {32'h3F800000, 2'd0, 1'b0, 1'b1, 32'h00000001, 1'b1, 1'b0, 1'b0}, // R3 1.0
    {32'h40200000, 2'd0, 1'b0, 1'b1, 32'h00000002, 1'b1, 1'b0, 1'b1}, // R3 2.5 near
    {32'h40200000, 2'd1, 1'b0, 1'b1, 32'h00000002, 1'b1, 1'b0, 1'b1}, // R3 2.5 down
    {32'h40200000, 2'd2, 1'b0, 1'b1, 32'h00000003, 1'b1, 1'b0, 1'b1}, // R3 2.5 up
    {32'h40200000, 2'd3, 1'b0, 1'b1, 32'h00000002, 1'b1, 1'b0, 1'b1}, // R3 2.5 zero
    {32'hC0200000, 2'd0, 1'b0, 1'b1, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b1}, // R3 -2.5
    {32'hC0200000, 2'd1, 1'b0, 1'b1, 32'hFFFFFFFD, 1'b1, 1'b0, 1'b1}, // R3
    {32'hC0200000, 2'd2, 1'b0, 1'b1, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b1}, // R3
    {32'hC0200000, 2'd3, 1'b0, 1'b1, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b1}, // R3
    {32'h40600000, 2'd0, 1'b0, 1'b1, 32'h00000004, 1'b1, 1'b0, 1'b1}, // R3 3.5 tie odd
    {32'hBFC00000, 2'd0, 1'b0, 1'b1, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b1}, // R3 -1.5
    {32'hBFC00000, 2'd2, 1'b0, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b1}, // R3
    {32'hC0F80000, 2'd0, 1'b0, 1'b1, 32'hFFFFFFF8, 1'b1, 1'b0, 1'b1}, // R3 -7.75
    {32'hC0F80000, 2'd1, 1'b0, 1'b1, 32'hFFFFFFF8, 1'b1, 1'b0, 1'b1}, // R3
    {32'hC0F80000, 2'd2, 1'b0, 1'b1, 32'hFFFFFFF9, 1'b1, 1'b0, 1'b1}, // R3
    {32'hC0F80000, 2'd3, 1'b0, 1'b1, 32'hFFFFFFF9, 1'b1, 1'b0, 1'b1}, // R3
    {32'h3E800000, 2'd0, 1'b0, 1'b1, 32'h00000000, 1'b1, 1'b0, 1'b1}, // R10 0.25
    {32'h3E800000, 2'd2, 1'b0, 1'b1, 32'h00000001, 1'b1, 1'b0, 1'b1}, // R10
    {32'hBE800000, 2'd1, 1'b0, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b1}, // R10 -0.25
    {32'hBE800000, 2'd3, 1'b0, 1'b1, 32'h00000000, 1'b1, 1'b0, 1'b1}, // R10
    {32'h3F000000, 2'd0, 1'b0, 1'b1, 32'h00000000, 1'b1, 1'b0, 1'b1}, // R10 0.5 tie
    {32'h3F400000, 2'd0, 1'b0, 1'b1, 32'h00000001, 1'b1, 1'b0, 1'b1}, // R10 0.75
    {32'h80000000, 2'd1, 1'b0, 1'b1, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R10 -0.0
    {32'h00000001, 2'd2, 1'b0, 1'b1, 32'h00000001, 1'b1, 1'b0, 1'b1}, // R10 denormal
    {32'h00000001, 2'd1, 1'b0, 1'b1, 32'h00000000, 1'b1, 1'b0, 1'b1}, // R10
    {32'h4E6E6B28, 2'd0, 1'b0, 1'b1, 32'h3B9ACA00, 1'b1, 1'b0, 1'b0}, // R9 exact 1e9
    {32'h4EFFFFFF, 2'd2, 1'b0, 1'b1, 32'h7FFFFF80, 1'b1, 1'b0, 1'b0}, // R6
    {32'hCEFFFFFF, 2'd1, 1'b0, 1'b1, 32'h80000080, 1'b1, 1'b0, 1'b0}, // R6
    {32'hCF000000, 2'd0, 1'b0, 1'b1, 32'h80000000, 1'b1, 1'b0, 1'b0}, // R6 -2^31 valid
    {32'hCF000000, 2'd2, 1'b1, 1'b0, 32'h80000000, 1'b1, 1'b0, 1'b0}, // R6
    {32'h4F000000, 2'd0, 1'b0, 1'b1, 32'h80000000, 1'b1, 1'b1, 1'b0}, // R6 2^31
    {32'h4F000000, 2'd3, 1'b1, 1'b1, 32'h80000000, 1'b1, 1'b1, 1'b0}, // R6
    {32'hCF000001, 2'd2, 1'b0, 1'b1, 32'h80000000, 1'b1, 1'b1, 1'b0}, // R6 below -2^31
    {32'h53800000, 2'd0, 1'b0, 1'b1, 32'h80000000, 1'b1, 1'b1, 1'b0}, // R7 2^40
    {32'h00000000, 2'd0, 1'b0, 1'b1, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R10 +0.0
    {32'h7F800000, 2'd0, 1'b0, 1'b1, 32'h80000000, 1'b1, 1'b1, 1'b0}, // R5 +inf
    {32'hFF800000, 2'd1, 1'b0, 1'b1, 32'h80000000, 1'b1, 1'b1, 1'b0}, // R5 -inf
    {32'h7FC00000, 2'd2, 1'b0, 1'b1, 32'h80000000, 1'b1, 1'b1, 1'b0}, // R5 qnan
    {32'h7F800001, 2'd3, 1'b0, 1'b1, 32'h80000000, 1'b1, 1'b1, 1'b0}, // R5 snan
    {32'h40300000, 2'd2, 1'b1, 1'b1, 32'h00000002, 1'b1, 1'b0, 1'b1}, // R4 2.75
    {32'hC0300000, 2'd1, 1'b1, 1'b1, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b1}, // R4 -2.75
    {32'h3F400000, 2'd0, 1'b1, 1'b1, 32'h00000000, 1'b1, 1'b0, 1'b1}, // R4 0.75
    {32'h3F800000, 2'd0, 1'b0, 1'b0, 32'h00000001, 1'b1, 1'b0, 1'b0}, // R7 mask low valid
    {32'h40A00000, 2'd3, 1'b0, 1'b0, 32'h00000005, 1'b1, 1'b0, 1'b0}, // R9 5.0 exact
    {32'h40A00000, 2'd2, 1'b1, 1'b1, 32'h00000005, 1'b1, 1'b0, 1'b0}, // R4
    {32'h3FC00000, 2'd0, 1'b0, 1'b1, 32'h00000002, 1'b1, 1'b0, 1'b1}  // R3 1.5 tie
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] operand = '0;
  logic [1:0]  rndMode = '0;
  logic        truncSel = 1'b0;
  logic        invMask = 1'b1;
  logic [31:0] result;
  logic        wrEn;
  logic        invFlag;
  logic        precFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcvt_int32 u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .operand  (operand),
    .rndMode  (rndMode),
    .truncSel (truncSel),
    .invMask  (invMask),
    .result   (result),
    .wrEn     (wrEn),
    .invFlag  (invFlag),
    .precFlag (precFlag)
  );

  task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s res/wr/inv/prec actual %h %b%b%b expected %h %b%b%b",
               req, act[34:3], act[2], act[1], act[0], exp[34:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic convert(input logic [31:0] op, input logic [1:0] md,
                         input logic tr, input logic mk);
    @(negedge clk);
    operand  = op;
    rndMode  = md;
    truncSel = tr;
    invMask  = mk;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {result, wrEn, invFlag, precFlag}, 35'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      convert(TBL[i][70:39], TBL[i][38:37], TBL[i][36], TBL[i][35]);
      check($sformatf("row %0d", i), {result, wrEn, invFlag, precFlag}, TBL[i][34:0]);
    end

    // R2: idle cycle after a request drops strobes, result held
    @(negedge clk);
    check("R2", {result, wrEn, invFlag, precFlag}, {32'h00000002, 3'b000});

    // R8: unmasked invalid leaves result untouched
    convert(32'h40A00000, 2'd0, 1'b0, 1'b0);
    check("R8 setup", {result, wrEn, invFlag, precFlag}, {32'h00000005, 3'b100});
    convert(32'h7F800000, 2'd0, 1'b0, 1'b0);
    check("R8 inf", {result, wrEn, invFlag, precFlag}, {32'h00000005, 3'b010});
    convert(32'h4F000000, 2'd1, 1'b0, 1'b0);
    check("R8 range", {result, wrEn, invFlag, precFlag}, {32'h00000005, 3'b010});
    convert(32'h7FC00000, 2'd2, 1'b1, 1'b0);
    check("R8 nan", {result, wrEn, invFlag, precFlag}, {32'h00000005, 3'b010});
    @(negedge clk);
    check("R2 idle", {result, wrEn, invFlag, precFlag}, {32'h00000005, 3'b000});

    // R1: reset mid-run clears state
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 again", {result, wrEn, invFlag, precFlag}, 35'd0);
    rst_n = 1'b1;
    convert(32'hC0200000, 2'd1, 1'b0, 1'b1);
    check("R3 post-reset", {result, wrEn, invFlag, precFlag}, {32'hFFFFFFFD, 3'b101});

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule